// File: doc/BRIEF.md
# Router Input Port Flit Assembler and Bypass Selector

This block is the receive stage of a single router port. Narrow link units (phits) come in one per cycle with a valid strobe. The block packs every group of four phits into one wide flit. For each assembled flit it then makes one decision in one cycle. The flit is either sent straight to the crossbar over the bypass path, or it is written into the input FIFO of the virtual channel (VC) it belongs to. A flit that bypasses appears at the crossbar side on the cycle right after that decision.

The block also tracks messages. A header flit opens a message and gives its length. The following data flits belong to that message until the count runs out. For every VC the port keeps a credit count of free slots in the buffer downstream. Adaptive messages use this count for cut-through gating: a header on an adaptive route may bypass only when the downstream buffer can hold the whole message. Two status inputs come from the surrounding router. One says whether the current message already holds its output (so a data flit follows a winner). The other says whether another candidate contends for the header's output.

Top module: `rtr_inport_bypass`

## Requirements
- R1: Phits are packed in arrival order. The first phit of a group lands in flit bits [15:0], the second in [31:16], the third in [47:32] and the fourth in [63:48]. The packed flit is presented unchanged on the crossbar or FIFO data output.
- R2: A flit's outcome is registered. It appears on the outputs for exactly one cycle, in the cycle after the one in which its fourth phit was captured.
- R3: When no message is open, a flit with bit 63 set is a header. Bits [62:59] hold the number of data flits that follow it (0 to 15). Bit 58 set marks an adaptive route. Bits [54+VCW-1:54] hold the VC number, where VCW = log2(NUM_VC) and NUM_VC is a power of two.
- R4: A header on a deterministic route bypasses only when the contend input is low and the credit count of its VC is at least 1. Otherwise it is written to its VC's FIFO.
- R5: A header on an adaptive route bypasses only when the contend input is low and the credit count of its VC is at least its data-flit count plus one. Otherwise it is written to its VC's FIFO.
- R6: A data flit goes to the VC of its open message. It bypasses only when all three of these hold: the follow-winner input is high, every earlier flit of the message bypassed, and the VC has at least one credit. Otherwise it is written to that VC's FIFO. Once one flit of a message is buffered, the remaining flits of that message are buffered too.
- R7: Each accepted flit goes to exactly one place, either the crossbar or a single FIFO write enable, and never to both at once.
- R8: Every VC's credit count starts at DS_DEPTH after reset. It drops by one for each flit of that VC that bypasses, and rises by one for each cycle in which that VC's credit-return bit is high.
- R9: A flit that arrives while no message is open and that has bit 63 clear is dropped. It produces no crossbar output and no FIFO write, and it does not change the message state.
- R10: While reset is held and just after it, the crossbar valid and all FIFO write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Router clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phit_valid | input | 1 | A phit is present on phit_data |
| phit_data | input | 16 | Link phit |
| follow_win | input | 1 | The open message holds its output port |
| contend | input | 1 | Another candidate contends for the header's output |
| cred_ret | input | NUM_VC | Per-VC downstream credit return, one slot per cycle |
| xbar_valid | output | 1 | Bypassed flit valid toward the crossbar |
| xbar_flit | output | 64 | Bypassed flit |
| xbar_vc | output | VCW | VC of the bypassed flit |
| fifo_we | output | NUM_VC | Per-VC FIFO write enable |
| fifo_wdata | output | 64 | Flit written into the selected FIFO |

## Verification
The hardest case to reach from the ports is the adaptive header that sits exactly at the credit threshold. This requires the downstream credit of one VC to be driven to a known small value before such a header arrives. The directed part of the stimulus sends single-flit bypassing headers to spend credit down to the exact count. It then offers adaptive headers one flit under and exactly at the threshold, and follows them with data flits while the VC has no credit left. Random traffic then mixes message lengths, contention, the follow-winner status, stray flits and credit returns.

// File: rtl/rib_pkg.sv
package rib_pkg;
  localparam int PHIT_W  = 16;
  localparam int PHITS   = 4;
  localparam int FLIT_W  = PHIT_W * PHITS;
  localparam int HDR_BIT = 63;
  localparam int LEN_LO  = 59;
  localparam int LEN_W   = 4;
  localparam int ADP_BIT = 58;
  localparam int VC_LO   = 54;

  typedef logic [FLIT_W-1:0] flit_t;

  function automatic logic f_is_hdr(input flit_t f);
    return f[HDR_BIT];
  endfunction

  function automatic logic [LEN_W-1:0] f_len(input flit_t f);
    return f[LEN_LO +: LEN_W];
  endfunction

  function automatic logic f_adaptive(input flit_t f);
    return f[ADP_BIT];
  endfunction

  // credits a header needs before it may bypass
  function automatic int f_need(input flit_t f);
    return f[ADP_BIT] ? int'(f[LEN_LO +: LEN_W]) + 1 : 1;
  endfunction
endpackage

// File: rtl/rib_phit_packer.sv
module rib_phit_packer
  import rib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phit_valid,
  input  logic [PHIT_W-1:0] phit_data,
  output logic              flit_rdy,
  output flit_t             flit_data
);
  localparam int CW = $clog2(PHITS);

  logic [CW-1:0] slot_q;
  flit_t         buf_q;
  logic          rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      buf_q  <= '0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= phit_valid && (slot_q == CW'(PHITS-1));
      if (phit_valid) begin
        buf_q[slot_q*PHIT_W +: PHIT_W] <= phit_data;
        slot_q <= (slot_q == CW'(PHITS-1)) ? '0 : slot_q + 1'b1;
      end
    end
  end

  assign flit_rdy  = rdy_q;
  assign flit_data = buf_q;
endmodule

// File: rtl/rib_msg_tracker.sv
module rib_msg_tracker
  import rib_pkg::*;
#(
  parameter int VCW = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hdr_take,
  input  logic           data_take,
  input  flit_t          flit_data,
  input  logic           byp_take,
  output logic           msg_open,
  output logic [VCW-1:0] cur_vc,
  output logic           cur_byp
);
  logic [LEN_W-1:0] left_q;
  logic [VCW-1:0]   vc_q;
  logic             byp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      vc_q   <= '0;
      byp_q  <= 1'b0;
    end else if (hdr_take) begin
      left_q <= f_len(flit_data);
      vc_q   <= flit_data[VC_LO +: VCW];
      byp_q  <= byp_take;
    end else if (data_take) begin
      left_q <= left_q - 1'b1;
      byp_q  <= byp_q & byp_take;
    end
  end

  assign msg_open = (left_q != '0);
  assign cur_vc   = vc_q;
  assign cur_byp  = byp_q;
endmodule

// File: rtl/rib_credit_bank.sv
module rib_credit_bank #(
  parameter int NUM_VC   = 2,
  parameter int DS_DEPTH = 40,
  parameter int CRED_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_VC-1:0]        ret,
  input  logic [NUM_VC-1:0]        use_c,
  output logic [NUM_VC*CRED_W-1:0] cred_flat
);
  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [CRED_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= CRED_W'(DS_DEPTH);
      else        cnt_q <= cnt_q + CRED_W'(ret[v]) - CRED_W'(use_c[v]);
    end
    assign cred_flat[v*CRED_W +: CRED_W] = cnt_q;
  end
endmodule

// File: rtl/rtr_inport_bypass.sv
module rtr_inport_bypass
  import rib_pkg::*;
#(
  parameter int NUM_VC   = 2,
  parameter int DS_DEPTH = 40,
  localparam int VCW     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CRED_W  = $clog2(DS_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phit_valid,
  input  logic [15:0]       phit_data,
  input  logic              follow_win,
  input  logic              contend,
  input  logic [NUM_VC-1:0] cred_ret,
  output logic              xbar_valid,
  output logic [63:0]       xbar_flit,
  output logic [VCW-1:0]    xbar_vc,
  output logic [NUM_VC-1:0] fifo_we,
  output logic [63:0]       fifo_wdata
);
  logic                     flit_rdy;
  flit_t                    flit_data;
  logic                     msg_open;
  logic [VCW-1:0]           cur_vc;
  logic                     cur_byp;
  logic [NUM_VC*CRED_W-1:0] cred_flat;

  // named decision events, also seen by the checker
  logic           hdr_take, data_take, byp_take, buf_take, flit_hdr_bit;
  logic [VCW-1:0] flit_vc;
  logic [CRED_W-1:0] cred_sel;
  logic [NUM_VC-1:0] use_c;

  rib_phit_packer u_pack (
    .clk(clk), .rst_n(rst_n), .phit_valid(phit_valid), .phit_data(phit_data),
    .flit_rdy(flit_rdy), .flit_data(flit_data)
  );

  rib_msg_tracker #(.VCW(VCW)) u_trk (
    .clk(clk), .rst_n(rst_n), .hdr_take(hdr_take), .data_take(data_take),
    .flit_data(flit_data), .byp_take(byp_take),
    .msg_open(msg_open), .cur_vc(cur_vc), .cur_byp(cur_byp)
  );

  rib_credit_bank #(.NUM_VC(NUM_VC), .DS_DEPTH(DS_DEPTH), .CRED_W(CRED_W)) u_cred (
    .clk(clk), .rst_n(rst_n), .ret(cred_ret), .use_c(use_c), .cred_flat(cred_flat)
  );

  assign flit_hdr_bit = f_is_hdr(flit_data);
  assign hdr_take     = flit_rdy && !msg_open && flit_hdr_bit;
  assign data_take    = flit_rdy && msg_open;
  assign flit_vc      = msg_open ? cur_vc : flit_data[VC_LO +: VCW];
  assign cred_sel     = cred_flat[flit_vc*CRED_W +: CRED_W];

  // bypass check and buffer selection evaluated side by side
  always_comb begin
    byp_take = 1'b0;
    if (hdr_take)
      byp_take = !contend && (int'(cred_sel) >= f_need(flit_data));
    else if (data_take)
      byp_take = follow_win && cur_byp && (cred_sel != '0);
    buf_take = (hdr_take || data_take) && !byp_take;
    use_c    = '0;
    if (byp_take) use_c[flit_vc] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xbar_valid <= 1'b0;
      xbar_flit  <= '0;
      xbar_vc    <= '0;
      fifo_we    <= '0;
      fifo_wdata <= '0;
    end else begin
      xbar_valid <= byp_take;
      xbar_flit  <= flit_data;
      xbar_vc    <= flit_vc;
      fifo_wdata <= flit_data;
      fifo_we    <= '0;
      if (buf_take) fifo_we[flit_vc] <= 1'b1;
    end
  end
endmodule

// File: rtl/rib_chk.sv
module rib_chk #(
  parameter int NUM_VC   = 2,
  parameter int DS_DEPTH = 40,
  parameter int CRED_W   = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     phit_valid,
  input logic                     flit_rdy,
  input logic                     msg_open,
  input logic                     flit_hdr_bit,
  input logic                     xbar_valid,
  input logic [NUM_VC-1:0]        fifo_we,
  input logic [NUM_VC*CRED_W-1:0] cred_flat
);
  // R7
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xbar_valid && (fifo_we != '0)));

  // R7
  onehot_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_we));

  // R2
  out_after_flit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xbar_valid || (fifo_we != '0)) |-> $past(flit_rdy));

  // R1
  flit_after_phit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flit_rdy |-> $past(phit_valid));

  // R9
  stray_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_rdy && !msg_open && !flit_hdr_bit) |=> (!xbar_valid && (fifo_we == '0)));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!xbar_valid && (fifo_we == '0)));

  for (genvar v = 0; v < NUM_VC; v++) begin : g_c
    // R8
    cred_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cred_flat[v*CRED_W +: CRED_W]) <= DS_DEPTH);
  end
endmodule

bind rtr_inport_bypass rib_chk #(.NUM_VC(NUM_VC), .DS_DEPTH(DS_DEPTH), .CRED_W(CRED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phit_valid(phit_valid), .flit_rdy(flit_rdy),
  .msg_open(msg_open), .flit_hdr_bit(flit_hdr_bit), .xbar_valid(xbar_valid),
  .fifo_we(fifo_we), .cred_flat(cred_flat)
);

// File: tb/rtr_inport_bypass_tb.sv
module rtr_inport_bypass_tb;
  localparam int NV  = 2;
  localparam int DSD = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          phit_valid = 1'b0;
  logic [15:0]   phit_data = '0;
  logic          follow_win = 1'b0;
  logic          contend = 1'b0;
  logic [NV-1:0] cred_ret = '0;
  logic          xbar_valid;
  logic [63:0]   xbar_flit;
  logic [0:0]    xbar_vc;
  logic [NV-1:0] fifo_we;
  logic [63:0]   fifo_wdata;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // bench-side model of the port
  int m_cred[NV];
  int m_left = 0;
  int m_vc = 0;
  bit m_allbyp = 0;

  always #5 clk = ~clk;

  rtr_inport_bypass #(.NUM_VC(NV), .DS_DEPTH(DSD)) u_dut (
    .clk(clk), .rst_n(rst_n), .phit_valid(phit_valid), .phit_data(phit_data),
    .follow_win(follow_win), .contend(contend), .cred_ret(cred_ret),
    .xbar_valid(xbar_valid), .xbar_flit(xbar_flit), .xbar_vc(xbar_vc),
    .fifo_we(fifo_we), .fifo_wdata(fifo_wdata)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_hdr(input int len, input bit adp, input int vc);
    logic [63:0] f;
    f = {$urandom, $urandom};
    f[63] = 1'b1;
    f[62:59] = 4'(len);
    f[58] = adp;
    f[54] = 1'(vc);
    return f;
  endfunction

  // sends one flit, predicts its outcome, checks the pulse and its end
  task automatic send_flit(input logic [63:0] f, input bit fw, input bit ct);
    bit is_hdr, is_data, byp;
    int vc, need;
    string tag;
    is_data = (m_left != 0);
    is_hdr  = !is_data && f[63];
    vc      = is_data ? m_vc : int'(f[54]);
    byp     = 0;
    tag     = "R9";
    if (is_hdr) begin
      need = f[58] ? int'(f[62:59]) + 1 : 1;
      byp  = !ct && (m_cred[vc] >= need);
      tag  = f[58] ? "R5" : "R4";
    end else if (is_data) begin
      byp = fw && m_allbyp && (m_cred[vc] > 0);
      tag = "R6";
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      phit_valid = 1'b1;
      phit_data  = f[16*i +: 16];
      follow_win = fw;
      contend    = ct;
      @(posedge clk);
    end
    @(negedge clk);
    phit_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R2: outcome visible in the cycle after the flit is assembled
    chk({tag, " R2 bypass"}, 64'(xbar_valid), 64'(byp));
    chk({tag, " R7 fifo_we"}, 64'(fifo_we),
        (!byp && (is_hdr || is_data)) ? 64'(1 << vc) : 64'd0);
    if (byp) begin
      chk("R1 xbar_flit", xbar_flit, f);
      chk("R3 xbar_vc", 64'(xbar_vc), 64'(vc));
    end else if (is_hdr || is_data) begin
      chk("R1 fifo_wdata", fifo_wdata, f);
    end
    if (is_hdr) begin
      m_left = int'(f[62:59]);
      m_vc = vc;
      m_allbyp = byp;
    end else if (is_data) begin
      m_left--;
      m_allbyp = m_allbyp && byp;
    end
    if (byp) m_cred[vc]--;
    @(posedge clk);
    @(negedge clk);
    chk("R2 single pulse", 64'({xbar_valid, fifo_we}), 64'd0);
  endtask

  task automatic ret_credit(input int vc);
    @(negedge clk);
    cred_ret = '0;
    cred_ret[vc] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cred_ret = '0;
    m_cred[vc]++;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int v = 0; v < NV; v++) m_cred[v] = DSD;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10
    chk("R10 reset xbar_valid", 64'(xbar_valid), 64'd0);
    chk("R10 reset fifo_we", 64'(fifo_we), 64'd0);
    rst_n = 1'b1;

    // R1 fixed pattern; R4 clean header bypass
    send_flit({16'h8000, 16'hC0DE, 16'h2222, 16'h1111}, 1'b0, 1'b0);
    // R4 contended header buffered
    send_flit(mk_hdr(0, 0, 1), 1'b0, 1'b1);
    // R9 stray flit dropped, then a header still opens correctly
    send_flit(64'h0123_4567_89AB_CDEF, 1'b1, 1'b0);
    send_flit(mk_hdr(1, 0, 0), 1'b1, 1'b0);
    send_flit({1'b1, 63'h0}, 1'b1, 1'b0);   // R6 data flit with bit 63 set

    // R8/R5 threshold: spend vc0 credit down to 3
    while (m_cred[0] > 3) send_flit(mk_hdr(0, 0, 0), 1'b0, 1'b0);
    send_flit(mk_hdr(3, 1, 0), 1'b1, 1'b0);  // R5 needs 4, has 3: buffered
    for (int i = 0; i < 3; i++) send_flit({$urandom, $urandom}, 1'b1, 1'b0); // R6 stays buffered
    send_flit(mk_hdr(2, 1, 0), 1'b1, 1'b0);  // R5 exactly 3: bypass
    send_flit({$urandom, $urandom}, 1'b1, 1'b0);
    send_flit({$urandom, $urandom}, 1'b1, 1'b0);
    send_flit(mk_hdr(0, 0, 0), 1'b0, 1'b0);  // R4 zero credit: buffered
    ret_credit(0);                           // R8 return restores one slot
    send_flit(mk_hdr(1, 0, 0), 1'b0, 1'b0);  // bypass, credit back to 0
    send_flit({$urandom, $urandom}, 1'b1, 1'b0); // R6 no credit: buffered
    for (int i = 0; i < DSD; i++) ret_credit(0);

    // random traffic
    for (int n = 0; n < 250; n++) begin
      if ($urandom_range(9) == 0) begin
        logic [63:0] s;
        s = {$urandom, $urandom};
        s[63] = 1'b0;
        send_flit(s, 1'($urandom), 1'($urandom));
      end
      begin
        int len;
        len = $urandom_range(5);
        send_flit(mk_hdr(len, 1'($urandom), int'($urandom_range(NV-1))),
                  1'b0, ($urandom_range(2) == 0));
        for (int d = 0; d < len; d++) begin
          send_flit({$urandom, $urandom}, ($urandom_range(3) != 0), 1'($urandom));
          if ($urandom_range(4) < 2) begin
            int rv;
            rv = int'($urandom_range(NV-1));
            if (m_cred[rv] < DSD) ret_credit(rv);
          end
        end
      end
      for (int v = 0; v < NV; v++)
        if (m_cred[v] < DSD && $urandom_range(1) == 1) ret_credit(v);
    end
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule